// File: doc/BRIEF.md
# Indirect Configuration Register Access Unit

This block gives a host processor access to a small bank of configuration registers through two I/O locations. The host first writes a full 32-bit selector to the address port. The selector holds an enable flag, a bus number, a device number, a function number and a dword register index. The host then reads or writes the data port. Writes use per-byte enables, so byte, 16-bit and 32-bit stores all work. A data-port access takes effect only when the selector names this block: the enable flag is set, the bus is zero, the device field equals this block's device number and the function is zero. Any other selector makes reads return all ones and makes writes do nothing.

Each register bit has one of three access rules: fixed, read/write, or write-one-to-clear. The device number has five bits. Its upper bits are a hardwired pattern and its lower bits are an identity taken from strap pins, which are captured when power-good rises. A reset-control bit lets software start a hard reset. That reset puts the bank back to its defaults, except for the bus-number byte, the version byte and the captured identity, which keep their values.

Top module: `cfg_access_unit`

## Requirements
- R1: A write to I/O dword port 0x33E (byte address 0CF8h) with all four byte enables set loads the selector. A write with any other byte-enable pattern leaves it unchanged. A read of that port returns the selector's bit 31 and bits 23:2, with every other bit read as zero.
- R2: Port 0x33F (byte address 0CFCh) is the data port. A data-port access hits only when selector bit 31 = 1, bits 23:16 = 0, bits 15:11 equal the device number and bits 10:8 = 0. Bits 7:2 then pick the register. A miss reads 0xFFFFFFFF and writes nothing. A request to either port raises io_claim in the same cycle.
- R3: The device number is {DEV_PATTERN[4:2], identity}. The identity register at index 18 reports the device number in bits 4:0 and the identity in bits 9:8. All its other bits read as zero.
- R4: The identity is loaded from strap_id on the first clock edge at which pwr_good is seen high after having been low. Changes to strap_id while pwr_good stays high have no effect.
- R5: A data-port write changes only the byte lanes whose io_be bit is set. Read/write bits never change in lanes whose enable is clear.
- R6: Index 0 reads {DEVICE_ID, VENDOR_ID} and index 2 reads {CLASS_CODE, REV_ID}, whatever is written to them. At index 1, command bits outside CMD_WMASK always read as zero.
- R7: Status bits 31:27 at index 1 are write-one-to-clear. err_evt[i] sets bit 27+i. Writing 1 to a bit (with io_be[3] set) clears it, and writing 0 leaves it unchanged. A set event wins over a clear in the same cycle.
- R8: Every index other than 0, 1, 2, 16, 17, 18 and 19 is reserved. A reserved index reads zero, writes to it change nothing, and the access is still claimed.
- R9: After power-on reset: the selector, command, status, bus and version bytes, reset-control bit and identity are all zero, and the scratch register at index 17 holds SCRATCH_RST.
- R10: Writing 1 to bit 1 of index 19 (byte lane 0) raises hard_rst_o for exactly one cycle. At the next edge the selector, command, status, scratch and reset-control bit return to their defaults. The bus byte (index 16, bits 7:0), the version byte (index 16, bits 15:8) and the identity keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwr_good | input | 1 | Power-good level, synchronous to clk |
| strap_id | input | ID_W | Identity strap pins |
| err_evt | input | STAT_W | Status event pulses, one per status bit |
| io_req | input | 1 | Host I/O request valid |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_port | input | 14 | I/O dword address (byte address bits 15:2) |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | Write data |
| io_claim | output | 1 | Request targets a port of this block |
| io_rdata | output | 32 | Read data, valid in the request cycle |
| hard_rst_o | output | 1 | One-cycle hard reset pulse |

## Verification
The bench keeps the default DEV_PATTERN of 11001 and a two-bit identity. This makes the reachable device number depend on the straps, so a selector that was correct before a power-good edge can miss after it. The bench sets SCRATCH_RST to a nonzero pattern and widens CMD_WMASK to an odd value. A hard reset therefore visibly restores the scratch register, and the checks see both writable and fixed command bits. Random selectors that sometimes miss on device, function, bus or enable are mixed with random byte enables and random status events. This drives the miss path, lane merging and the set-versus-clear race through many combinations.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned BE_W   = DW / 8;
  localparam int unsigned PORT_W = 14;
  localparam int unsigned IDX_W  = 6;
  localparam int unsigned DEV_W  = 5;

  typedef logic [DW-1:0] dword_t;

  // dword-granular I/O ports
  localparam logic [PORT_W-1:0] PORT_SEL  = 14'h33E;
  localparam logic [PORT_W-1:0] PORT_DATA = 14'h33F;

  // register indices (dword)
  localparam logic [IDX_W-1:0] IDX_IDS     = 6'd0;
  localparam logic [IDX_W-1:0] IDX_CMDSTAT = 6'd1;
  localparam logic [IDX_W-1:0] IDX_CLASS   = 6'd2;
  localparam logic [IDX_W-1:0] IDX_BUSVER  = 6'd16;
  localparam logic [IDX_W-1:0] IDX_SCRATCH = 6'd17;
  localparam logic [IDX_W-1:0] IDX_IDENT   = 6'd18;
  localparam logic [IDX_W-1:0] IDX_RSTCTL  = 6'd19;

  // selector bits that hold state
  localparam dword_t SEL_KEEP = 32'h80FF_FFFC;
  localparam int unsigned RST_TRIG_BIT = 1;

  function automatic dword_t lane_merge(input dword_t old_v, input dword_t new_v,
                                        input logic [BE_W-1:0] be);
    dword_t r;
    r = old_v;
    for (int b = 0; b < int'(BE_W); b++) begin
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/cfg_strap_capture.sv
module cfg_strap_capture #(
  parameter int unsigned ID_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_good,
  input  logic [ID_W-1:0] strap_in,
  output logic [ID_W-1:0] id_q,
  output logic            pg_rise
);
  logic            pg_q;
  logic [ID_W-1:0] id_d;

  // rise seen when level is high and the sampled copy is low
  assign pg_rise = pwr_good & ~pg_q;

  always_comb begin
    id_d = id_q;
    if (pg_rise) id_d = strap_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0;
      id_q <= '0;
    end else begin
      pg_q <= pwr_good;
      id_q <= id_d;
    end
  end
endmodule

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              io_req,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [BE_W-1:0]   io_be,
  input  dword_t            io_wdata,
  input  logic [DEV_W-1:0]  own_dev,
  output dword_t            sel_q,
  output logic              at_sel,
  output logic              at_data,
  output logic              hit,
  output logic [IDX_W-1:0]  reg_idx
);
  dword_t sel_d;
  logic   sel_load;

  assign at_sel   = io_req && (io_port == PORT_SEL);
  assign at_data  = io_req && (io_port == PORT_DATA);
  assign sel_load = at_sel && io_wr && (io_be == {BE_W{1'b1}});

  // selector layout: [31] enable, [23:16] bus, [15:11] device, [10:8] function, [7:2] index
  assign hit     = sel_q[31] && (sel_q[23:16] == 8'h00) &&
                   (sel_q[15:11] == own_dev) && (sel_q[10:8] == 3'b000);
  assign reg_idx = sel_q[7:2];

  always_comb begin
    sel_d = sel_q;
    if (soft_rst)      sel_d = '0;
    else if (sel_load) sel_d = io_wdata & SEL_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_pkg::*;
#(
  parameter int unsigned STAT_W      = 5,
  parameter logic [15:0] CMD_WMASK   = 16'h0146,
  parameter dword_t      SCRATCH_RST = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [BE_W-1:0]  wr_be,
  input  dword_t           wr_data,
  input  logic [STAT_W-1:0] err_evt,
  output logic [15:0]      cmd_q,
  output logic [STAT_W-1:0] stat_q,
  output logic [7:0]       bus_q,
  output logic [7:0]       ver_q,
  output dword_t           scr_q,
  output logic             trig_q
);
  localparam int unsigned STAT_LSB = DW - STAT_W;

  logic [15:0]       cmd_d;
  logic [STAT_W-1:0] stat_d;
  logic [7:0]        bus_d, ver_d;
  dword_t            scr_d;
  logic              trig_d;
  logic              wr_cmd, wr_busver, wr_scr, wr_rst;
  dword_t            cmd_merged, scr_merged;

  assign wr_cmd    = wr_en && (wr_idx == IDX_CMDSTAT);
  assign wr_busver = wr_en && (wr_idx == IDX_BUSVER);
  assign wr_scr    = wr_en && (wr_idx == IDX_SCRATCH);
  assign wr_rst    = wr_en && (wr_idx == IDX_RSTCTL);

  assign cmd_merged = lane_merge({16'h0000, cmd_q}, wr_data, wr_be);
  assign scr_merged = lane_merge(scr_q, wr_data, wr_be);

  // command: read/write only where the mask allows
  always_comb begin
    cmd_d = cmd_q;
    if (soft_rst)    cmd_d = '0;
    else if (wr_cmd) cmd_d = cmd_merged[15:0] & CMD_WMASK;
  end

  // status: one write-one-to-clear cell per bit, set wins
  for (genvar i = 0; i < int'(STAT_W); i++) begin : g_stat
    logic clr_i;
    assign clr_i     = wr_cmd && wr_be[BE_W-1] && wr_data[STAT_LSB + i];
    assign stat_d[i] = soft_rst ? 1'b0 : (err_evt[i] | (stat_q[i] & ~clr_i));
  end

  // preserved bytes: soft reset deliberately not consulted
  always_comb begin
    bus_d = bus_q;
    ver_d = ver_q;
    if (wr_busver && wr_be[0]) bus_d = wr_data[7:0];
    if (wr_busver && wr_be[1]) ver_d = wr_data[15:8];
  end

  always_comb begin
    scr_d = scr_q;
    if (soft_rst)    scr_d = SCRATCH_RST;
    else if (wr_scr) scr_d = scr_merged;
  end

  always_comb begin
    trig_d = trig_q;
    if (soft_rst)                trig_d = 1'b0;
    else if (wr_rst && wr_be[0]) trig_d = wr_data[RST_TRIG_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      stat_q <= '0;
      scr_q  <= SCRATCH_RST;
      trig_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      stat_q <= stat_d;
      scr_q  <= scr_d;
      trig_q <= trig_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      ver_q <= '0;
    end else begin
      bus_q <= bus_d;
      ver_q <= ver_d;
    end
  end
endmodule

// File: rtl/cfg_access_unit.sv
module cfg_access_unit
  import cfg_pkg::*;
#(
  parameter logic [15:0]     VENDOR_ID   = 16'h1D5A,
  parameter logic [15:0]     DEVICE_ID   = 16'h0C51,
  parameter logic [7:0]      REV_ID      = 8'h03,
  parameter logic [23:0]     CLASS_CODE  = 24'h060000,
  parameter logic [DEV_W-1:0] DEV_PATTERN = 5'b11001,
  parameter int unsigned     ID_W        = 2,
  parameter int unsigned     STAT_W      = 5,
  parameter logic [15:0]     CMD_WMASK   = 16'h0146,
  parameter logic [31:0]     SCRATCH_RST = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic [ID_W-1:0]   strap_id,
  input  logic [STAT_W-1:0] err_evt,
  input  logic              io_req,
  input  logic              io_wr,
  input  logic [13:0]       io_port,
  input  logic [3:0]        io_be,
  input  logic [31:0]       io_wdata,
  output logic              io_claim,
  output logic [31:0]       io_rdata,
  output logic              hard_rst_o
);
  localparam int unsigned FIX_W = DEV_W - ID_W;

  logic [ID_W-1:0]   id_q;
  logic              pg_rise;
  logic [DEV_W-1:0]  own_dev;
  dword_t            sel_q;
  logic              at_sel, at_data, hit;
  logic [IDX_W-1:0]  reg_idx;
  logic              soft_rst, bank_wr;
  logic [15:0]       cmd_q;
  logic [STAT_W-1:0] stat_q;
  logic [7:0]        bus_q, ver_q;
  dword_t            scr_q, bank_rd;
  logic              trig_q;

  assign own_dev  = {DEV_PATTERN[DEV_W-1:ID_W], id_q};
  assign soft_rst = trig_q;
  assign bank_wr  = at_data && io_wr && hit;

  cfg_strap_capture #(.ID_W(ID_W)) u_strap (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .strap_in (strap_id),
    .id_q     (id_q),
    .pg_rise  (pg_rise)
  );

  cfg_addr_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .io_req   (io_req),
    .io_wr    (io_wr),
    .io_port  (io_port),
    .io_be    (io_be),
    .io_wdata (io_wdata),
    .own_dev  (own_dev),
    .sel_q    (sel_q),
    .at_sel   (at_sel),
    .at_data  (at_data),
    .hit      (hit),
    .reg_idx  (reg_idx)
  );

  cfg_reg_bank #(
    .STAT_W      (STAT_W),
    .CMD_WMASK   (CMD_WMASK),
    .SCRATCH_RST (SCRATCH_RST)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .wr_en    (bank_wr),
    .wr_idx   (reg_idx),
    .wr_be    (io_be),
    .wr_data  (io_wdata),
    .err_evt  (err_evt),
    .cmd_q    (cmd_q),
    .stat_q   (stat_q),
    .bus_q    (bus_q),
    .ver_q    (ver_q),
    .scr_q    (scr_q),
    .trig_q   (trig_q)
  );

  // register read mux; unlisted indices are reserved and read zero
  always_comb begin
    bank_rd = '0;
    case (reg_idx)
      IDX_IDS:     bank_rd = {DEVICE_ID, VENDOR_ID};
      IDX_CMDSTAT: bank_rd = {stat_q, {(16-STAT_W){1'b0}}, cmd_q};
      IDX_CLASS:   bank_rd = {CLASS_CODE, REV_ID};
      IDX_BUSVER:  bank_rd = {16'h0000, ver_q, bus_q};
      IDX_SCRATCH: bank_rd = scr_q;
      IDX_IDENT:   bank_rd = {16'h0000, {(8-ID_W){1'b0}}, id_q,
                              {(8-DEV_W){1'b0}}, own_dev};
      IDX_RSTCTL:  bank_rd = dword_t'(trig_q) << RST_TRIG_BIT;
      default:     bank_rd = '0;
    endcase
  end

  always_comb begin
    io_rdata = '0;
    if (!io_wr) begin
      if (at_sel)       io_rdata = sel_q;
      else if (at_data) io_rdata = hit ? bank_rd : '1;
    end
  end

  assign io_claim   = at_sel || at_data;
  assign hard_rst_o = trig_q;

  // FIX_W kept for documentation of the split between pattern and straps
  if (FIX_W == 0) begin : g_no_fixed
  end
endmodule

// File: rtl/cfg_access_sva.sv
module cfg_access_sva
  import cfg_pkg::*;
#(
  parameter int unsigned ID_W   = 2,
  parameter int unsigned STAT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_req,
  input logic              io_wr,
  input logic [13:0]       io_port,
  input logic [3:0]        io_be,
  input logic [31:0]       io_wdata,
  input logic [31:0]       io_rdata,
  input logic [STAT_W-1:0] err_evt,
  input logic              hard_rst_o,
  input logic [31:0]       sel_q,
  input logic              hit,
  input logic              pg_rise,
  input logic [ID_W-1:0]   id_q,
  input logic [STAT_W-1:0] stat_q,
  input logic [15:0]       cmd_q,
  input logic [7:0]        bus_q,
  input logic [7:0]        ver_q
);
  p_sel_partial_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_wr && io_port == PORT_SEL && io_be != 4'hF && !hard_rst_o)
      |=> $stable(sel_q));

  p_miss_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_wr && io_port == PORT_DATA && !hit) |-> (io_rdata == 32'hFFFF_FFFF));

  p_id_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_rise |=> $stable(id_q));

  p_w1c_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_wr && io_port == PORT_DATA && hit && sel_q[7:2] == IDX_CMDSTAT &&
     io_be[3] && io_wdata[31] && !err_evt[STAT_W-1] && !hard_rst_o)
      |=> !stat_q[STAT_W-1]);

  p_evt_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt[0] && !hard_rst_o) |=> stat_q[0]);

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst_o |=> !hard_rst_o);

  p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst_o |=> ($stable(bus_q) && $stable(ver_q) && $stable(id_q)));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst_o |=> (cmd_q == 16'h0000 && sel_q == 32'h0 && stat_q == '0));
endmodule

bind cfg_access_unit cfg_access_sva #(.ID_W(ID_W), .STAT_W(STAT_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_req     (io_req),
  .io_wr      (io_wr),
  .io_port    (io_port),
  .io_be      (io_be),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .err_evt    (err_evt),
  .hard_rst_o (hard_rst_o),
  .sel_q      (sel_q),
  .hit        (hit),
  .pg_rise    (pg_rise),
  .id_q       (id_q),
  .stat_q     (stat_q),
  .cmd_q      (cmd_q),
  .bus_q      (bus_q),
  .ver_q      (ver_q)
);

// File: tb/tb_cfg_access_unit.sv
module tb_cfg_access_unit;
  localparam logic [15:0] T_VEND  = 16'h1D5A;
  localparam logic [15:0] T_DEVID = 16'h0C51;
  localparam logic [7:0]  T_REV   = 8'h03;
  localparam logic [23:0] T_CLASS = 24'h060000;
  localparam logic [15:0] T_CMDM  = 16'h0147;
  localparam logic [31:0] T_SCR   = 32'h5A5A_C3C3;
  localparam logic [13:0] P_SEL   = 14'h33E;
  localparam logic [13:0] P_DATA  = 14'h33F;

  logic        clk, rst_n, pwr_good;
  logic [1:0]  strap_id;
  logic [4:0]  err_evt;
  logic        io_req, io_wr;
  logic [13:0] io_port;
  logic [3:0]  io_be;
  logic [31:0] io_wdata;
  logic        io_claim;
  logic [31:0] io_rdata;
  logic        hard_rst_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  logic [31:0] m_sel;
  logic [15:0] m_cmd;
  logic [4:0]  m_stat;
  logic [7:0]  m_bus, m_ver;
  logic [31:0] m_scr;
  logic        m_trig;
  logic [1:0]  m_id;

  cfg_access_unit #(
    .VENDOR_ID(T_VEND), .DEVICE_ID(T_DEVID), .REV_ID(T_REV), .CLASS_CODE(T_CLASS),
    .DEV_PATTERN(5'b11001), .ID_W(2), .STAT_W(5), .CMD_WMASK(T_CMDM), .SCRATCH_RST(T_SCR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_id(strap_id), .err_evt(err_evt),
    .io_req(io_req), .io_wr(io_wr), .io_port(io_port), .io_be(io_be), .io_wdata(io_wdata),
    .io_claim(io_claim), .io_rdata(io_rdata), .hard_rst_o(hard_rst_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [4:0] m_dev();
    return {3'b110, m_id};
  endfunction

  function automatic logic m_hit();
    return m_sel[31] && m_sel[23:16] == 8'h00 && m_sel[15:11] == m_dev() && m_sel[10:8] == 3'b000;
  endfunction

  function automatic logic [31:0] mk_sel(input logic en, input logic [7:0] bus,
                                        input logic [4:0] dev, input logic [2:0] fn,
                                        input logic [5:0] idx);
    return {en, 7'b0, bus, dev, fn, idx, 2'b00};
  endfunction

  function automatic logic [31:0] merge_bytes(input logic [31:0] o, input logic [31:0] n,
                                              input logic [3:0] be);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[k] = be[k/8] ? n[k] : o[k];
    return r;
  endfunction

  function automatic logic [31:0] exp_cfg();
    case (m_sel[7:2])
      6'd0:    return {T_DEVID, T_VEND};
      6'd1:    return {m_stat, 11'b0, m_cmd};
      6'd2:    return {T_CLASS, T_REV};
      6'd16:   return {16'h0, m_ver, m_bus};
      6'd17:   return m_scr;
      6'd18:   return {16'h0, 6'b0, m_id, 3'b0, m_dev()};
      6'd19:   return {30'b0, m_trig, 1'b0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_for();
    if (!m_hit()) return "R2";
    case (m_sel[7:2])
      6'd0, 6'd2: return "R6";
      6'd1:       return "R7";
      6'd16:      return "R10";
      6'd17:      return "R5";
      6'd18:      return "R3";
      6'd19:      return "R10";
      default:    return "R8";
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_soft_reset();
    m_sel = 32'h0; m_cmd = 16'h0; m_stat = 5'h0; m_scr = T_SCR; m_trig = 1'b0;
  endtask

  task automatic io_write(input logic [13:0] port, input logic [3:0] be,
                          input logic [31:0] d, input logic [4:0] evt);
    logic [4:0] clr;
    io_req = 1'b1; io_wr = 1'b1; io_port = port; io_be = be; io_wdata = d; err_evt = evt;
    @(posedge clk);
    @(negedge clk);
    io_req = 1'b0; io_wr = 1'b0; err_evt = 5'h0;
    clr = 5'h0;
    if (port == P_SEL && be == 4'hF) m_sel = d & 32'h80FF_FFFC;
    else if (port == P_DATA && m_hit()) begin
      case (m_sel[7:2])
        6'd1: begin
          m_cmd = merge_bytes({16'h0, m_cmd}, d, be)
                  & {16'h0, T_CMDM};
          if (be[3]) clr = d[31:27];
        end
        6'd16: begin
          if (be[0]) m_bus = d[7:0];
          if (be[1]) m_ver = d[15:8];
        end
        6'd17: m_scr = merge_bytes(m_scr, d, be);
        6'd19: if (be[0]) m_trig = d[1];
        default: ;
      endcase
    end
    m_stat = (m_stat & ~clr) | evt;
    if (m_trig) begin
      check(hard_rst_o === 1'b1, "R10 pulse high", {31'b0, hard_rst_o}, 32'h1);
      @(negedge clk);
      model_soft_reset();
      check(hard_rst_o === 1'b0, "R10 pulse one cycle", {31'b0, hard_rst_o}, 32'h0);
    end
  endtask

  task automatic set_sel(input logic [31:0] v);
    io_write(P_SEL, 4'hF, v, 5'h0);
  endtask

  task automatic io_read(input logic [13:0] port, input string tag);
    logic [31:0] exp;
    io_req = 1'b1; io_wr = 1'b0; io_port = port; io_be = 4'hF;
    #5;
    if (port == P_SEL)       exp = m_sel;
    else if (port == P_DATA) exp = m_hit() ? exp_cfg() : 32'hFFFF_FFFF;
    else                     exp = 32'h0;
    check(io_rdata === exp, tag, io_rdata, exp);
    check(io_claim === (port == P_SEL || port == P_DATA), "R2 claim",
          {31'b0, io_claim}, {31'b0, (port == P_SEL || port == P_DATA)});
    io_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_own(input logic [5:0] idx, input string tag);
    set_sel(mk_sel(1'b1, 8'h00, m_dev(), 3'b000, idx));
    io_read(P_DATA, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pwr_good = 1'b0; strap_id = 2'b10; err_evt = 5'h0;
    io_req = 1'b0; io_wr = 1'b0; io_port = 14'h0; io_be = 4'h0; io_wdata = 32'h0;
    m_bus = 8'h0; m_ver = 8'h0; m_id = 2'b00;
    model_soft_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 power-on defaults
    check(hard_rst_o === 1'b0, "R9 no reset pulse", {31'b0, hard_rst_o}, 32'h0);
    io_read(P_SEL, "R9 selector zero");
    read_own(6'd17, "R9 scratch default");
    read_own(6'd1, "R9 command/status zero");
    read_own(6'd16, "R9 bus/version zero");
    read_own(6'd18, "R9 identity zero");

    // R4 strap capture on power-good rise, R3 device number
    pwr_good = 1'b1;
    @(negedge clk);
    m_id = 2'b10;
    strap_id = 2'b01;
    repeat (2) @(negedge clk);
    read_own(6'd18, "R3 R4 identity after rise");
    set_sel(mk_sel(1'b1, 8'h00, 5'b11000, 3'b000, 6'd0));
    io_read(P_DATA, "R2 R3 old device misses");
    pwr_good = 1'b0;
    @(negedge clk);
    strap_id = 2'b11;
    pwr_good = 1'b1;
    @(negedge clk);
    m_id = 2'b11;
    strap_id = 2'b00;
    @(negedge clk);
    read_own(6'd18, "R4 second rise");

    // R1 partial selector writes
    set_sel(mk_sel(1'b1, 8'h00, m_dev(), 3'b000, 6'd17));
    io_write(P_SEL, 4'h3, 32'h0000_0000, 5'h0);
    io_read(P_SEL, "R1 word write ignored");
    io_write(P_SEL, 4'h8, 32'hFFFF_FFFF, 5'h0);
    io_read(P_SEL, "R1 byte write ignored");
    set_sel(32'hFFFF_FFFF);
    io_read(P_SEL, "R1 reserved selector bits zero");

    // R2 misses: function, bus, enable
    set_sel(mk_sel(1'b1, 8'h00, m_dev(), 3'b001, 6'd17));
    io_write(P_DATA, 4'hF, 32'h1111_1111, 5'h0);
    io_read(P_DATA, "R2 function miss");
    set_sel(mk_sel(1'b1, 8'h01, m_dev(), 3'b000, 6'd17));
    io_read(P_DATA, "R2 bus miss");
    set_sel(mk_sel(1'b0, 8'h00, m_dev(), 3'b000, 6'd17));
    io_write(P_DATA, 4'hF, 32'h2222_2222, 5'h0);
    io_read(P_DATA, "R2 enable miss");
    read_own(6'd17, "R2 missed writes dropped");

    // R5 byte lanes
    io_write(P_DATA, 4'b0101, 32'hAABB_CCDD, 5'h0);
    io_read(P_DATA, "R5 lanes 0 and 2");
    io_write(P_DATA, 4'b1000, 32'h1200_0000, 5'h0);
    io_read(P_DATA, "R5 lane 3");

    // R6 fixed registers
    set_sel(mk_sel(1'b1, 8'h00, m_dev(), 3'b000, 6'd0));
    io_write(P_DATA, 4'hF, 32'h0, 5'h0);
    io_read(P_DATA, "R6 identifiers fixed");
    set_sel(mk_sel(1'b1, 8'h00, m_dev(), 3'b000, 6'd2));
    io_write(P_DATA, 4'hF, 32'hFFFF_FFFF, 5'h0);
    io_read(P_DATA, "R6 class fixed");
    set_sel(mk_sel(1'b1, 8'h00, m_dev(), 3'b000, 6'd1));
    io_write(P_DATA, 4'h3, 32'h0000_FFFF, 5'h0);
    io_read(P_DATA, "R6 command mask");

    // R7 write-one-to-clear
    io_write(P_DATA, 4'h0, 32'h0, 5'h1F);
    io_read(P_DATA, "R7 events set");
    io_write(P_DATA, 4'h8, 32'h0000_0000, 5'h0);
    io_read(P_DATA, "R7 zero keeps");
    io_write(P_DATA, 4'h8, 32'h2000_0000, 5'h0);
    io_read(P_DATA, "R7 one clears");
    io_write(P_DATA, 4'h8, 32'h8000_0000, 5'h10);
    io_read(P_DATA, "R7 set wins");

    // R8 reserved index
    set_sel(mk_sel(1'b1, 8'h00, m_dev(), 3'b000, 6'd37));
    io_write(P_DATA, 4'hF, 32'hDEAD_BEEF, 5'h0);
    io_read(P_DATA, "R8 reserved reads zero");

    // R10 hard reset keeps bus, version, identity
    set_sel(mk_sel(1'b1, 8'h00, m_dev(), 3'b000, 6'd16));
    io_write(P_DATA, 4'h3, 32'h0000_7E3C, 5'h0);
    set_sel(mk_sel(1'b1, 8'h00, m_dev(), 3'b000, 6'd19));
    io_write(P_DATA, 4'h1, 32'h0000_0002, 5'h0);
    io_read(P_SEL, "R10 selector cleared");
    read_own(6'd16, "R10 bus/version kept");
    read_own(6'd17, "R10 scratch default");
    read_own(6'd1, "R10 command/status cleared");
    read_own(6'd18, "R10 identity kept");

    // constrained random mix
    for (int k = 0; k < 1500; k++) begin
      int r;
      logic [5:0] idx;
      logic [4:0] dv;
      r = int'($urandom % 10);
      case ($urandom % 8)
        0: idx = 6'd0;  1: idx = 6'd1;  2: idx = 6'd2;  3: idx = 6'd16;
        4: idx = 6'd17; 5: idx = 6'd18; 6: idx = 6'd19;
        default: idx = 6'($urandom);
      endcase
      dv = ($urandom % 5 == 0) ? 5'($urandom) : m_dev();
      if (r < 2) begin
        set_sel(mk_sel(($urandom % 8) != 0, ($urandom % 8 == 0) ? 8'($urandom) : 8'h00,
                       dv, ($urandom % 8 == 0) ? 3'($urandom) : 3'b000, idx));
      end else if (r == 2) begin
        io_write(P_SEL, 4'($urandom), $urandom, 5'h0);
      end else if (r < 6) begin
        io_write(P_DATA, 4'($urandom), $urandom,
                 ($urandom % 4 == 0) ? 5'($urandom) : 5'h0);
      end else if (r < 9) begin
        io_read(P_DATA, tag_for());
      end else begin
        io_read(P_SEL, "R1 random selector");
      end
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule